// File: doc/BRIEF.md
# Repeating Block Memory Transfer Engine

This block moves bytes from one place in memory to another on behalf of a processor core. Software hands it a 16-bit source pointer, a 16-bit destination pointer and a 16-bit count. A start pulse then launches the copy. Every iteration fetches one byte from the source address, stores it at the destination address, steps the pointers and decrements the count.

The engine has two operating styles. A single-step copy performs exactly one iteration. A repeat copy keeps looping until the count reaches zero. A direction input picks between stepping up and stepping down. Two hold inputs can pin either pointer in place, which is how data is streamed out of a fixed port address or into one. Flag outputs report the state after the copy in the way a processor's block-copy instruction does: the parity/overflow flag shows that the count is still nonzero, and the subtract and half-carry flags read as cleared.

Memory is reached through a single port. The engine raises a read strobe, holds it until ready, captures the byte, and then raises a write strobe carrying that byte until ready again.

Top module: `blk_copy_engine`

## Requirements
- R1: Each iteration reads the byte at the current source pointer and writes that same byte to the current destination pointer.
- R2: With both hold inputs low, both pointers move by one per iteration: up when `dir` is 0, down (modulo 2^16) when `dir` is 1.
- R3: With `hold_dst`=1 and `hold_src`=0, only the source pointer moves (by +1 or -1 per `dir`). The destination pointer keeps its start value.
- R4: With `hold_src`=1 and `hold_dst`=0, only the destination pointer moves (by +1 or -1 per `dir`). The source pointer keeps its start value. With both hold inputs high, neither pointer moves.
- R5: Each accepted write decrements the count by exactly one. A single-step copy (`rep`=0) performs one iteration and leaves count equal to start count minus one.
- R6: A repeat copy (`rep`=1) keeps iterating while the count after a decrement is nonzero, and it stops with count 0 after exactly start-count iterations.
- R7: After each iteration `flag_pv` is 1 if the decremented count is nonzero and 0 otherwise.
- R8: `flag_n` and `flag_h` read 0 after any copy.
- R9: A single-step copy started with count 0 copies one byte and leaves count 0xFFFF with `flag_pv`=1.
- R10: `done` is high for exactly one cycle, in the cycle after the final write is accepted. `busy` is low in that cycle, and the final pointer and count values stay on the outputs afterwards.
- R11: `mem_rd` and `mem_wr` are never high together. A strobe stays high until `mem_ready` is seen, and a read always comes before the write of the same iteration.
- R12: A `start` pulse while `busy` is high is ignored: the running copy finishes with the values it was started with.
- R13: After reset the engine is idle, with `busy`, `done`, `mem_rd` and `mem_wr` low and pointers and count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a copy when idle |
| rep | input | 1 | 1 = repeat until count is zero, 0 = single step |
| dir | input | 1 | 0 = step pointers up, 1 = step down |
| hold_src | input | 1 | Keep the source pointer fixed |
| hold_dst | input | 1 | Keep the destination pointer fixed |
| src_in | input | 16 | Start source pointer |
| dst_in | input | 16 | Start destination pointer |
| cnt_in | input | 16 | Start count |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ready during a read |
| mem_ready | input | 1 | Memory accepts the current strobe |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle end-of-copy pulse |
| src_ptr | output | 16 | Current source pointer |
| dst_ptr | output | 16 | Current destination pointer |
| count | output | 16 | Current count |
| flag_pv | output | 1 | Count nonzero after the last decrement |
| flag_n | output | 1 | Subtract flag (cleared) |
| flag_h | output | 1 | Half-carry flag (cleared) |

## Verification
The properties assume that `mem_ready` is only meaningful while a strobe is raised. They also assume that the mode inputs seen at a start pulse describe the whole copy. The bench memory model honours this: it raises ready only in answer to a strobe held for a chosen latency, and it drops ready in the cycle after acceptance. The stimulus changes the mode and data inputs only on falling edges. Repeat copies are never started with count 0, because that would run 65536 iterations. Wrap-around of the count is exercised through a single step instead.

// File: rtl/blk_copy_engine.sv
module blk_copy_engine #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          rep,
  input  logic          dir,
  input  logic          hold_src,
  input  logic          hold_dst,
  input  logic [AW-1:0] src_in,
  input  logic [AW-1:0] dst_in,
  input  logic [CW-1:0] cnt_in,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [CW-1:0] count,
  output logic          flag_pv,
  output logic          flag_n,
  output logic          flag_h
);
  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} state_t;

  state_t        st;
  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] data_q;
  logic          rep_q, dir_q, hold_src_q, hold_dst_q;
  logic          pv_q, done_q;

  logic [AW-1:0] step;
  logic [CW-1:0] cnt_dec;
  logic          more;

  assign step    = dir_q ? {AW{1'b1}} : AW'(1);
  assign cnt_dec = cnt_q - CW'(1);
  assign more    = |cnt_dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      src_q      <= '0;
      dst_q      <= '0;
      cnt_q      <= '0;
      data_q     <= '0;
      rep_q      <= 1'b0;
      dir_q      <= 1'b0;
      hold_src_q <= 1'b0;
      hold_dst_q <= 1'b0;
      pv_q       <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          src_q      <= src_in;
          dst_q      <= dst_in;
          cnt_q      <= cnt_in;
          rep_q      <= rep;
          dir_q      <= dir;
          hold_src_q <= hold_src;
          hold_dst_q <= hold_dst;
          st         <= S_READ;
        end
        S_READ: if (mem_ready) begin
          data_q <= mem_rdata;
          st     <= S_WRITE;
        end
        S_WRITE: if (mem_ready) begin
          if (!hold_src_q) src_q <= src_q + step;
          if (!hold_dst_q) dst_q <= dst_q + step;
          cnt_q <= cnt_dec;
          pv_q  <= more;
          if (rep_q && more) begin
            st <= S_READ;
          end else begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_rd    = (st == S_READ);
  assign mem_wr    = (st == S_WRITE);
  assign mem_addr  = (st == S_WRITE) ? dst_q : src_q;
  assign mem_wdata = data_q;
  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign src_ptr   = src_q;
  assign dst_ptr   = dst_q;
  assign count     = cnt_q;
  assign flag_pv   = pv_q;
  assign flag_n    = 1'b0;
  assign flag_h    = 1'b0;
endmodule

// File: rtl/blk_copy_engine_chk.sv
module blk_copy_engine_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          mem_ready,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] src_ptr,
  input logic [AW-1:0] dst_ptr,
  input logic [CW-1:0] count,
  input logic          flag_pv,
  input logic          rep_q,
  input logic          dir_q,
  input logic          hold_src_q,
  input logic          hold_dst_q
);
  logic acc;
  assign acc = mem_wr && mem_ready;

  assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_read_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> mem_rd);

  assert_read_then_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_ready) |=> mem_wr);

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> count == $past(count) - CW'(1));

  assert_flag_pv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> flag_pv == (count != '0));

  assert_repeat_continues_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rep_q && count != CW'(1)) |=> mem_rd);

  assert_src_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hold_src_q) |=> $stable(src_ptr));

  assert_dst_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && hold_dst_q) |=> $stable(dst_ptr));

  assert_src_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !hold_src_q && !dir_q) |=> src_ptr == $past(src_ptr) + AW'(1));

  assert_dst_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !hold_dst_q && dir_q) |=> dst_ptr == $past(dst_ptr) - AW'(1));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind blk_copy_engine blk_copy_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .mem_ready(mem_ready), .busy(busy), .done(done), .src_ptr(src_ptr),
  .dst_ptr(dst_ptr), .count(count), .flag_pv(flag_pv), .rep_q(rep_q),
  .dir_q(dir_q), .hold_src_q(hold_src_q), .hold_dst_q(hold_dst_q)
);

// File: tb/test_blk_copy_engine.sv
module test_blk_copy_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, rep = 1'b0, dir = 1'b0, hold_src = 1'b0, hold_dst = 1'b0;
  logic [15:0] src_in = '0, dst_in = '0, cnt_in = '0;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, mem_ready, busy, done, flag_pv, flag_n, flag_h;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] src_ptr, dst_ptr, count;

  int n_total = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  int   lat = 0;
  int   wcnt = 0;
  logic rdy = 1'b0;

  always #2.5 clk = ~clk;

  blk_copy_engine i_blk_copy_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .rep(rep), .dir(dir),
    .hold_src(hold_src), .hold_dst(hold_dst), .src_in(src_in), .dst_in(dst_in),
    .cnt_in(cnt_in), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .busy(busy), .done(done), .src_ptr(src_ptr), .dst_ptr(dst_ptr),
    .count(count), .flag_pv(flag_pv), .flag_n(flag_n), .flag_h(flag_h)
  );

  assign mem_ready = rdy;
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (rdy) begin
      rdy  <= 1'b0;
      wcnt <= 0;
    end else if (mem_rd || mem_wr) begin
      if (wcnt >= lat) rdy <= 1'b1;
      else wcnt <= wcnt + 1;
    end
    if (mem_wr && rdy) mem[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
  endtask

  task automatic run(input logic [15:0] s, input logic [15:0] d, input logic [15:0] c,
                     input logic hs, input logic hd, input logic dr, input logic rp,
                     input bit poke);
    logic [15:0] ss = s, dd = d, cc = c;
    int iters = rp ? ((c == 0) ? 65536 : int'(c)) : 1;
    int dones = 0;
    int bad = 0;
    string preq;
    for (int i = 0; i < iters; i++) begin
      ref_mem[dd[7:0]] = ref_mem[ss[7:0]];
      if (!hs) ss = dr ? ss - 16'd1 : ss + 16'd1;
      if (!hd) dd = dr ? dd - 16'd1 : dd + 16'd1;
      cc = cc - 16'd1;
    end
    @(negedge clk);
    src_in = s; dst_in = d; cnt_in = c; hold_src = hs; hold_dst = hd; dir = dr; rep = rp;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      src_in = 16'h00F0; dst_in = 16'h00F8; cnt_in = 16'd9; hold_src = ~hs; dir = ~dr; rep = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (done) begin
        dones++;
        check("R10", "busy with done", {31'd0, busy}, 32'd0);
      end
      if (!busy && dones > 0) break;
    end
    @(negedge clk);
    check("R10", "done pulses", dones, 1);
    check("R10", "done after one cycle", {31'd0, done}, 32'd0);
    preq = (hs && !hd) ? "R4" : (hd && !hs) ? "R3" : (hs && hd) ? "R4" : "R2";
    if (poke) preq = "R12";
    check(preq, "src_ptr", {16'd0, src_ptr}, {16'd0, ss});
    check(preq, "dst_ptr", {16'd0, dst_ptr}, {16'd0, dd});
    check(poke ? "R12" : (rp ? "R6" : "R5"), "count", {16'd0, count}, {16'd0, cc});
    check("R7", "flag_pv", {31'd0, flag_pv}, {31'd0, cc != 16'd0});
    check("R8", "flag_n/h", {30'd0, flag_n, flag_h}, 32'd0);
    for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) bad++;
    check(poke ? "R12" : "R1", "memory mismatches", bad, 0);
    for (int i = 0; i < 256; i++) ref_mem[i] = mem[i];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    check("R13", "busy", {31'd0, busy}, 32'd0);
    check("R13", "done", {31'd0, done}, 32'd0);
    check("R13", "strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
    check("R13", "pointers/count", {src_ptr, dst_ptr ^ count}, 32'd0);
    rst_n = 1'b1;
    for (int m = 0; m < 16; m++) begin
      for (int ci = 0; ci < 3; ci++) begin
        logic [15:0] c = (ci == 0) ? 16'd1 : (ci == 1) ? 16'd2 : 16'd5;
        logic dr = m[1];
        lat = (m + ci) % 3;
        run(dr ? 16'h0030 : 16'h0010, dr ? 16'h00A0 : 16'h0080, c,
            m[3], m[2], dr, m[0], 1'b0);
      end
    end
    lat = 1;
    run(16'h0001, 16'h00C2, 16'd3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    run(16'h12FE, 16'hFFFE, 16'd4, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    // R9: single step from count 0 wraps to 0xFFFF
    run(16'h0040, 16'h0050, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9", "wrapped count", {16'd0, count}, 32'h0000FFFF);
    check("R9", "flag_pv", {31'd0, flag_pv}, 32'd1);
    lat = 2;
    run(16'h0060, 16'h0070, 16'd6, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    finished = 1;
    summary();
    $finish;
  end
endmodule